// File: doc/BRIEF.md
# Video Memory Block Copy Engine

This block moves a run of bytes from anywhere in a 16-bit CPU address space into the video memory window. Software programs a source pointer and a destination pointer through four byte-wide registers, then writes a length byte to a fifth register. That write starts the copy. The length is counted in 16-byte units. The source and destination pointers are aligned to 16 bytes. The destination is an offset inside an 8 KB window based at 0x8000.

While a copy runs, the block is the master of a simple byte bus. For each byte it first reads the source and then writes the destination. Every access holds its request until the memory side acknowledges it. A busy output covers the whole copy. A one-cycle done pulse marks the end. The length register reads back with its top bit set once the copy has finished.

Top module: `vram_copy_engine`

## Requirements
- R1: After reset all five registers read 0x00, and `busy`, `done` and `memReq` are low.
- R2: The registers sit at consecutive addresses from `REG_BASE` (default 0xFF51): +0 source high, +1 source low, +2 destination high, +3 destination low, +4 length/start. A read of any other address returns 0x00.
- R3: The source high register keeps all 8 bits. The source low register keeps only bits 7:4 and reads bits 3:0 as zero.
- R4: The destination high register keeps only bits 4:0. The destination low register keeps only bits 7:4. The effective destination is {dstHigh, dstLow} + 0x8000.
- R5: A write to the length register while idle starts a copy of ((value & 0x7F) + 1) × 16 bytes. Bit 7 of the written value has no effect on the length.
- R6: Byte i is read from source + i and written to destination + i, with i counting upward from 0. Both addresses wrap modulo 2^16. The written data equals the data that was read.
- R7: Each byte takes exactly one read (`memWe`=0) followed by one write (`memWe`=1). A request keeps its address and direction stable until the cycle in which `memAck` is high.
- R8: `busy` rises in the cycle after the starting write. It stays high until the last write is acknowledged. In the following cycle `busy` is low and `done` is high for exactly one cycle.
- R9: A read of the length register returns {flag, last written bits 6:0}. The flag is 0 from the start of a copy until it completes, and 1 after completion.
- R10: A write to the length register while `busy` is high is ignored: neither the readback nor the number of bytes copied changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgAddr | input | 16 | Register access address |
| cfgWrEn | input | 1 | Register write strobe |
| cfgWrData | input | 8 | Register write data |
| cfgRdData | output | 8 | Register read data for `cfgAddr` (combinational) |
| memReq | output | 1 | Bus access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 16 | Bus address |
| memWdata | output | 8 | Bus write data |
| memRdata | input | 8 | Bus read data, valid with `memAck` |
| memAck | input | 1 | Access acknowledge |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the engine with its default parameters: a 7-bit length in 16-byte units, an 8 KB destination window at 0x8000, and the register block at 0xFF51. With these values the longest copy of 2048 bytes is within reach, as is a source run that crosses 0xFFFF back to 0x0000. The acknowledge latency is randomized, so both back-to-back accesses and held requests occur. This lets the bench check address stability and read/write ordering under both kinds of timing.

// File: rtl/vram_copy_pkg.sv
package vram_copy_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } copyState_t;

  typedef struct packed {
    logic loadPtrs;
    logic capture;
    logic advance;
    logic finish;
    logic selDst;
  } copyStrobe_t;

endpackage

// File: rtl/vram_copy_datapath.sv
module vram_copy_datapath
  import vram_copy_pkg::*;
#(
  parameter int          LEN_W        = 7,
  parameter int          UNIT_LOG2    = 4,
  parameter int          DST_WIN_LOG2 = 13,
  parameter logic [15:0] DST_BASE     = 16'h8000,
  parameter logic [15:0] REG_BASE     = 16'hFF51
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] cfgAddr,
  input  logic        cfgWrEn,
  input  logic [7:0]  cfgWrData,
  output logic [7:0]  cfgRdData,
  output logic        startHit,
  input  copyStrobe_t strobe,
  input  logic [7:0]  memRdata,
  output logic [15:0] memAddr,
  output logic [7:0]  memWdata,
  output logic        lastByte
);

  localparam int          CNT_W   = LEN_W + UNIT_LOG2;
  localparam int          HI_KEEP = DST_WIN_LOG2 - 8;
  localparam logic [7:0]  LO_MASK = 8'(8'hFF << UNIT_LOG2);
  localparam logic [7:0]  HI_MASK = 8'((9'd1 << HI_KEEP) - 9'd1);
  localparam logic [2:0]  SEL_SRC_HI = 3'd0;
  localparam logic [2:0]  SEL_SRC_LO = 3'd1;
  localparam logic [2:0]  SEL_DST_HI = 3'd2;
  localparam logic [2:0]  SEL_DST_LO = 3'd3;
  localparam logic [2:0]  SEL_LEN    = 3'd4;
  localparam logic [15:0] REG_COUNT  = 16'd5;

  logic [7:0]       srcHiQ, srcLoQ, dstHiQ, dstLoQ;
  logic [6:0]       lenValQ;
  logic             doneFlagQ;
  logic [15:0]      srcPtrQ, dstPtrQ;
  logic [CNT_W-1:0] byteLeftQ;
  logic [7:0]       dataQ;

  logic [15:0] regOff;
  logic        regHit;
  logic [2:0]  regSel;
  logic [15:0] srcStart, dstStart;

  assign regOff   = cfgAddr - REG_BASE;
  assign regHit   = regOff < REG_COUNT;
  assign regSel   = regOff[2:0];
  assign startHit = cfgWrEn && regHit && (regSel == SEL_LEN);

  assign srcStart = {srcHiQ, srcLoQ};
  assign dstStart = {dstHiQ, dstLoQ} + DST_BASE;

  // Address registers: masked on write, free to change at any time
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcHiQ <= '0;
      srcLoQ <= '0;
      dstHiQ <= '0;
      dstLoQ <= '0;
    end else if (cfgWrEn && regHit) begin
      case (regSel)
        SEL_SRC_HI: srcHiQ <= cfgWrData;
        SEL_SRC_LO: srcLoQ <= cfgWrData & LO_MASK;
        SEL_DST_HI: dstHiQ <= cfgWrData & HI_MASK;
        SEL_DST_LO: dstLoQ <= cfgWrData & LO_MASK;
        default:    ;
      endcase
    end
  end

  // Length / status register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenValQ   <= '0;
      doneFlagQ <= 1'b0;
    end else if (strobe.loadPtrs) begin
      lenValQ   <= cfgWrData[6:0];
      doneFlagQ <= 1'b0;
    end else if (strobe.finish) begin
      doneFlagQ <= 1'b1;
    end
  end

  // Working pointers and remaining-byte counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcPtrQ   <= '0;
      dstPtrQ   <= '0;
      byteLeftQ <= '0;
    end else if (strobe.loadPtrs) begin
      srcPtrQ   <= srcStart;
      dstPtrQ   <= dstStart;
      byteLeftQ <= {cfgWrData[LEN_W-1:0], {UNIT_LOG2{1'b1}}};
    end else if (strobe.advance) begin
      srcPtrQ   <= srcPtrQ + 16'd1;
      dstPtrQ   <= dstPtrQ + 16'd1;
      byteLeftQ <= byteLeftQ - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               dataQ <= '0;
    else if (strobe.capture) dataQ <= memRdata;
  end

  assign lastByte = (byteLeftQ == '0);
  assign memAddr  = strobe.selDst ? dstPtrQ : srcPtrQ;
  assign memWdata = dataQ;

  always_comb begin
    cfgRdData = 8'h00;
    if (regHit) begin
      case (regSel)
        SEL_SRC_HI: cfgRdData = srcHiQ;
        SEL_SRC_LO: cfgRdData = srcLoQ;
        SEL_DST_HI: cfgRdData = dstHiQ;
        SEL_DST_LO: cfgRdData = dstLoQ;
        SEL_LEN:    cfgRdData = {doneFlagQ, lenValQ};
        default:    cfgRdData = 8'h00;
      endcase
    end
  end

  AST_SRC_LO_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    (srcLoQ & ~LO_MASK) == 8'h00); // R3
  AST_DST_HI_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (dstHiQ & ~HI_MASK) == 8'h00); // R4
  AST_DST_START_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadPtrs |=> dstPtrQ >= DST_BASE); // R4
  AST_WRITE_ECHOES_READ: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> memWdata == $past(memRdata)); // R6

endmodule

// File: rtl/vram_copy_ctrl.sv
module vram_copy_ctrl
  import vram_copy_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startHit,
  input  logic        memAck,
  input  logic        lastByte,
  output logic        memReq,
  output logic        memWe,
  output logic        busy,
  output logic        done,
  output copyStrobe_t strobe
);

  copyState_t stateQ, stateD;
  logic       doneQ;

  always_comb begin
    stateD          = stateQ;
    strobe          = '0;
    strobe.selDst   = (stateQ == ST_WRITE);
    case (stateQ)
      ST_IDLE: begin
        if (startHit) begin
          strobe.loadPtrs = 1'b1;
          stateD          = ST_READ;
        end
      end
      ST_READ: begin
        if (memAck) begin
          strobe.capture = 1'b1;
          stateD         = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (memAck) begin
          if (lastByte) begin
            strobe.finish = 1'b1;
            stateD        = ST_IDLE;
          end else begin
            strobe.advance = 1'b1;
            stateD         = ST_READ;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= strobe.finish;
    end
  end

  assign memReq = (stateQ == ST_READ) || (stateQ == ST_WRITE);
  assign memWe  = (stateQ == ST_WRITE);
  assign busy   = (stateQ != ST_IDLE);
  assign done   = doneQ;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startHit) |=> busy); // R8
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startHit) |-> !strobe.loadPtrs); // R10

endmodule

// File: rtl/vram_copy_engine.sv
module vram_copy_engine
  import vram_copy_pkg::*;
#(
  parameter int          LEN_W        = 7,
  parameter int          UNIT_LOG2    = 4,
  parameter int          DST_WIN_LOG2 = 13,
  parameter logic [15:0] DST_BASE     = 16'h8000,
  parameter logic [15:0] REG_BASE     = 16'hFF51
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] cfgAddr,
  input  logic        cfgWrEn,
  input  logic [7:0]  cfgWrData,
  output logic [7:0]  cfgRdData,
  output logic        memReq,
  output logic        memWe,
  output logic [15:0] memAddr,
  output logic [7:0]  memWdata,
  input  logic [7:0]  memRdata,
  input  logic        memAck,
  output logic        busy,
  output logic        done
);

  copyStrobe_t strobe;
  logic        startHit;
  logic        lastByte;

  vram_copy_datapath #(
    .LEN_W       (LEN_W),
    .UNIT_LOG2   (UNIT_LOG2),
    .DST_WIN_LOG2(DST_WIN_LOG2),
    .DST_BASE    (DST_BASE),
    .REG_BASE    (REG_BASE)
  ) uDatapath (
    .clk      (clk),
    .rstN     (rstN),
    .cfgAddr  (cfgAddr),
    .cfgWrEn  (cfgWrEn),
    .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData),
    .startHit (startHit),
    .strobe   (strobe),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .lastByte (lastByte)
  );

  vram_copy_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .startHit(startHit),
    .memAck  (memAck),
    .lastByte(lastByte),
    .memReq  (memReq),
    .memWe   (memWe),
    .busy    (busy),
    .done    (done),
    .strobe  (strobe)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe))); // R7
  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe && memAck) |=> (memReq && memWe)); // R7
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq); // R8
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (!busy && $past(busy) && $past(memAck) && $past(memWe))); // R8

endmodule

// File: tb/vram_copy_engine_test.sv
module vram_copy_engine_test;

  localparam logic [15:0] A_SRC_HI = 16'hFF51;
  localparam logic [15:0] A_SRC_LO = 16'hFF52;
  localparam logic [15:0] A_DST_HI = 16'hFF53;
  localparam logic [15:0] A_DST_LO = 16'hFF54;
  localparam logic [15:0] A_LEN    = 16'hFF55;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cfgAddr = '0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgWrData = '0;
  logic [7:0]  cfgRdData;
  logic        memReq, memWe, busy, done;
  logic [15:0] memAddr;
  logic [7:0]  memWdata;
  logic [7:0]  memRdata = '0;
  logic        memAck = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;
  int cycleCount = 0;

  logic [15:0] expSrc, expDst;
  int readIdx, writeIdx;
  int waitLeft;

  always #2 clk = ~clk;

  vram_copy_engine uut (
    .clk(clk), .rstN(rstN), .cfgAddr(cfgAddr), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck), .busy(busy), .done(done)
  );

  function automatic logic [7:0] srcByte(logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  task automatic check(bit ok, string req, int actual, int expected, string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, actual, expected);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > 180000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below 180000 cycles", cycleCount);
      finishRun();
    end
  end

  // Memory responder: random latency, checks ordering and addresses (R6, R7)
  always @(negedge clk) begin
    if (memAck) begin
      memAck = 1'b0;
    end else if (memReq && rstN) begin
      if (waitLeft > 0) begin
        waitLeft--;
      end else begin
        memAck = 1'b1;
        waitLeft = $urandom % 3;
        if (!memWe) begin
          check(readIdx == writeIdx, "R7", readIdx, writeIdx, "read issued before prior write");
          check(memAddr == 16'(expSrc + readIdx), "R6", memAddr, 16'(expSrc + readIdx), "read address");
          memRdata = srcByte(memAddr);
          readIdx++;
        end else begin
          check(writeIdx + 1 == readIdx, "R7", writeIdx + 1, readIdx, "write without one read");
          check(memAddr == 16'(expDst + writeIdx), "R6", memAddr, 16'(expDst + writeIdx), "write address");
          check(memWdata == srcByte(16'(expSrc + writeIdx)), "R6", memWdata,
                srcByte(16'(expSrc + writeIdx)), "write data");
          writeIdx++;
        end
      end
    end
  end

  task automatic regWrite(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cfgAddr = a; cfgWrData = d; cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic regRead(logic [15:0] a, output logic [7:0] d);
    cfgAddr = a;
    #1;
    d = cfgRdData;
  endtask

  task automatic runCopy(logic [7:0] sh, logic [7:0] sl, logic [7:0] dh,
                         logic [7:0] dl, logic [7:0] len, bit poke);
    logic [7:0] rd;
    int nBytes;
    int guard;
    bit prevBusy;
    regWrite(A_SRC_HI, sh);
    regWrite(A_SRC_LO, sl);
    regWrite(A_DST_HI, dh);
    regWrite(A_DST_LO, dl);
    expSrc   = {sh, sl & 8'hF0};
    expDst   = 16'({dh & 8'h1F, dl & 8'hF0} + 16'h8000);
    nBytes   = (int'(len & 8'h7F) + 1) * 16;
    readIdx  = 0;
    writeIdx = 0;
    waitLeft = $urandom % 3;
    regWrite(A_LEN, len);
    check(busy == 1'b1, "R8", busy, 1, "busy after start write");
    regRead(A_LEN, rd);
    check(rd == {1'b0, len[6:0]}, "R9", rd, {1'b0, len[6:0]}, "status while busy");
    if (poke) begin
      regWrite(A_LEN, 8'h00);
      regRead(A_LEN, rd);
      check(rd == {1'b0, len[6:0]}, "R10", rd, {1'b0, len[6:0]}, "status after busy write");
    end
    guard = 0;
    prevBusy = 1'b1;
    while (!done && guard < 40000) begin
      prevBusy = busy;
      @(negedge clk);
      guard++;
    end
    check(done == 1'b1, "R8", done, 1, "done pulse seen");
    check(busy == 1'b0 && prevBusy, "R8", {prevBusy, busy}, 2, "busy until end then low");
    check(writeIdx == nBytes, "R5", writeIdx, nBytes, "bytes written");
    check(readIdx == nBytes, "R7", readIdx, nBytes, "bytes read");
    regRead(A_LEN, rd);
    check(rd == {1'b1, len[6:0]}, "R9", rd, {1'b1, len[6:0]}, "status after completion");
    @(negedge clk);
    check(done == 1'b0, "R8", done, 0, "done lasts one cycle");
  endtask

  initial begin
    logic [7:0] rd;
    void'($urandom(32'd20240611));
    waitLeft = 0;
    expSrc = '0; expDst = '0; readIdx = 0; writeIdx = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !memReq, "R1", {busy, done, memReq}, 0, "outputs after reset");
    for (int k = 0; k < 5; k++) begin
      regRead(16'(A_SRC_HI + k), rd);
      check(rd == 8'h00, "R1", rd, 0, "register after reset");
    end
    // Register masks
    regWrite(A_SRC_HI, 8'hFF);
    regWrite(A_SRC_LO, 8'hFF);
    regWrite(A_DST_HI, 8'hFF);
    regWrite(A_DST_LO, 8'hFF);
    regRead(A_SRC_HI, rd); check(rd == 8'hFF, "R3", rd, 8'hFF, "source high");
    regRead(A_SRC_LO, rd); check(rd == 8'hF0, "R3", rd, 8'hF0, "source low mask");
    regRead(A_DST_HI, rd); check(rd == 8'h1F, "R4", rd, 8'h1F, "dest high mask");
    regRead(A_DST_LO, rd); check(rd == 8'hF0, "R4", rd, 8'hF0, "dest low mask");
    regWrite(16'hFF50, 8'hAB);
    regRead(16'hFF50, rd); check(rd == 8'h00, "R2", rd, 0, "unmapped below");
    regWrite(16'hFF56, 8'hCD);
    regRead(16'hFF56, rd); check(rd == 8'h00, "R2", rd, 0, "unmapped above");
    check(!busy, "R2", busy, 0, "unmapped write starts nothing");

    // Directed corners
    runCopy(8'h12, 8'h37, 8'h05, 8'hA9, 8'h00, 1'b0);  // shortest, masked pointers
    runCopy(8'hFF, 8'hF3, 8'h1F, 8'hF0, 8'h01, 1'b0);  // source wraps to 0x0000
    runCopy(8'h40, 8'h00, 8'h00, 8'h00, 8'h83, 1'b1);  // bit7 ignored, busy write ignored (R10)
    runCopy(8'hC0, 8'h10, 8'h1E, 8'h20, 8'hFF, 1'b0);  // longest copy, 2048 bytes
    // Random copies
    for (int t = 0; t < 12; t++) begin
      runCopy(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
              8'($urandom) & 8'h8F, ($urandom % 4) == 0);
    end
    finishRun();
  end

endmodule